// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between a clock synthesizer and the output pads of a system clock generator. It receives a processor-rate clock and a PCI clock running at half that rate, and drives two groups of gated outputs from them: a processor group and a PCI group. It also drives one PCI output that is never stopped. Each group has its own asynchronous active-low halt request. Each output has its own enable bit, which comes from a configuration register that lives outside the block.

A halt request counts only while the block is in power-management mode, that is, while `halt_dis_i` is 0. When `halt_dis_i` is 1, the request pins are in use for other purposes and are disregarded. Each group synchronizes its own request with a two-flop chain clocked by that group's own clock. Every output is gated by a latch that is open only while the source clock is low. As a result, an output always parks low, and it always resumes with a high pulse of full width. An asynchronous active-low reset presets both synchronizer chains to the running value.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst_n_i` is low, both synchronizer chains hold the running value, so every enabled output toggles even if a halt request is active. After release, a pending request takes effect with the normal latency.
- R2: When `halt_dis_i` is 1, both halt inputs are disregarded and every enabled output keeps toggling. When `halt_dis_i` returns to 0, a halt request that is still held low stops its group.
- R3: Every high pulse on every output has the full high width of its source clock: 4 ns for the processor group and 8 ns for the PCI outputs. A stopped output stays low for the whole time it is stopped.
- R4: The processor group stops and starts in fewer than 4 processor clock cycles. If `cpu_halt_n_i` falls between two rising edges, the outputs still pulse on the next two rising edges and stay low from the third onward. If it rises between two rising edges, the first output pulse starts on the third rising edge.
- R5: The PCI group follows the same edge counts as R4, counted in rising edges of `pci_clk_i`, in response to `pci_halt_n_i`.
- R6: A processor halt leaves the PCI group outputs and `pci_free_o` toggling.
- R7: A PCI halt stops only `pci_clk_o`. The processor outputs and `pci_free_o` keep toggling.
- R8: An enable bit of 0 in `cpu_en_i[i]` or `pci_en_i[i]` holds output bit i of that group low, whatever the halt state. It does not affect the other bits, and it is applied during the next low phase of the source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | Processor-rate source clock |
| pci_clk_i | input | 1 | PCI source clock, half the processor rate, rising edges aligned |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| halt_dis_i | input | 1 | 1 = halt requests disregarded; 0 = power-management mode |
| cpu_halt_n_i | input | 1 | Asynchronous active-low halt request for the processor group |
| pci_halt_n_i | input | 1 | Asynchronous active-low halt request for the PCI group |
| cpu_en_i | input | N_CPU (5) | Per-output enable for the processor group, 1 = enabled |
| pci_en_i | input | N_PCI (6) | Per-output enable for the PCI group, 1 = enabled |
| cpu_clk_o | output | N_CPU (5) | Gated processor clocks |
| pci_clk_o | output | N_PCI (6) | Gated PCI clocks |
| pci_free_o | output | 1 | PCI clock that is never halted, routed through the same gate path |

## Verification
The hardest case to reach is a restart or an enable change that lands right where a clock edge could cut a pulse short. The bench therefore changes every request and enable bit one nanosecond after a rising edge, while the source clock is high. A monitor measures the width of every high pulse on all twelve outputs throughout the run. The latency counts are taken by sampling the outputs in each high phase after the request changes, and the reset case is reached by holding a halt request active across reset.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  // A group should run unless power-management mode is on and its request is low.
  function automatic logic run_wanted(input logic halt_dis, input logic halt_n);
    return halt_dis | halt_n;
  endfunction

  // A single output lane is enabled when its group runs and its configuration bit is set.
  function automatic logic lane_enable(input logic run, input logic cfg);
    return run & cfg;
  endfunction
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  // The chain is preset to the running value.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '1;
    else          chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o
);
  logic en_lat;

  // The enable passes only while the clock is low, so the AND gate cannot cut a high pulse.
  always_latch begin
    if (!clk_i) en_lat <= en_i;
  end

  assign clk_o = clk_i & en_lat;
endmodule

// File: rtl/clkstop_group.sv
module clkstop_group
  import clkstop_pkg::*;
#(
  parameter int unsigned LANES  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             run_req_i,
  input  logic [LANES-1:0] cfg_en_i,
  output logic             run_s_o,
  output logic [LANES-1:0] clk_o
);
  logic [LANES-1:0] lane_en;

  clkstop_sync #(.STAGES(STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .d_i     (run_req_i),
    .q_o     (run_s_o)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_en[g] = lane_enable(run_s_o, cfg_en_i[g]);
    clkstop_gate u_gate (
      .clk_i (clk_i),
      .en_i  (lane_en[g]),
      .clk_o (clk_o[g])
    );
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int unsigned N_CPU       = 5,
  parameter int unsigned N_PCI       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             cpu_clk_i,
  input  logic             pci_clk_i,
  input  logic             rst_n_i,
  input  logic             halt_dis_i,
  input  logic             cpu_halt_n_i,
  input  logic             pci_halt_n_i,
  input  logic [N_CPU-1:0] cpu_en_i,
  input  logic [N_PCI-1:0] pci_en_i,
  output logic [N_CPU-1:0] cpu_clk_o,
  output logic [N_PCI-1:0] pci_clk_o,
  output logic             pci_free_o
);
  // Named internal events, exposed for the bound checker.
  logic cpu_run_req, pci_run_req;
  logic cpu_run_s, pci_run_s;

  // The mode is folded in before synchronization, so a change of mode is synchronized too.
  assign cpu_run_req = run_wanted(halt_dis_i, cpu_halt_n_i);
  assign pci_run_req = run_wanted(halt_dis_i, pci_halt_n_i);

  clkstop_group #(.LANES(N_CPU), .STAGES(SYNC_STAGES)) u_cpu_grp (
    .clk_i     (cpu_clk_i),
    .rst_n_i   (rst_n_i),
    .run_req_i (cpu_run_req),
    .cfg_en_i  (cpu_en_i),
    .run_s_o   (cpu_run_s),
    .clk_o     (cpu_clk_o)
  );

  clkstop_group #(.LANES(N_PCI), .STAGES(SYNC_STAGES)) u_pci_grp (
    .clk_i     (pci_clk_i),
    .rst_n_i   (rst_n_i),
    .run_req_i (pci_run_req),
    .cfg_en_i  (pci_en_i),
    .run_s_o   (pci_run_s),
    .clk_o     (pci_clk_o)
  );

  // The never-stopped output goes through an identical gate so its delay matches the gated lanes.
  clkstop_gate u_free_gate (
    .clk_i (pci_clk_i),
    .en_i  (1'b1),
    .clk_o (pci_free_o)
  );
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
  parameter int unsigned N_CPU       = 5,
  parameter int unsigned N_PCI       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic             cpu_clk_i,
  input logic             pci_clk_i,
  input logic             rst_n_i,
  input logic             halt_dis_i,
  input logic             cpu_halt_n_i,
  input logic             pci_halt_n_i,
  input logic [N_CPU-1:0] cpu_en_i,
  input logic [N_PCI-1:0] pci_en_i,
  input logic [N_CPU-1:0] cpu_clk_o,
  input logic [N_PCI-1:0] pci_clk_o,
  input logic             pci_free_o,
  input logic             cpu_run_s,
  input logic             pci_run_s
);
  // Edges seen since reset release, saturating at 3.
  logic [1:0] cpu_age, pci_age;

  always_ff @(posedge cpu_clk_i or negedge rst_n_i) begin
    if (!rst_n_i)              cpu_age <= 2'd0;
    else if (cpu_age != 2'd3)  cpu_age <= cpu_age + 2'd1;
  end

  always_ff @(posedge pci_clk_i or negedge rst_n_i) begin
    if (!rst_n_i)              pci_age <= 2'd0;
    else if (pci_age != 2'd3)  pci_age <= pci_age + 2'd1;
  end

  if (SYNC_STAGES == 2) begin : g_lat
    // R4 R2
    cpu_sync_latency_chk: assert property (@(posedge cpu_clk_i) disable iff (!rst_n_i)
      (cpu_age >= 2'd2) |-> (cpu_run_s == ($past(halt_dis_i, 2) | $past(cpu_halt_n_i, 2))));
    // R5 R2
    pci_sync_latency_chk: assert property (@(posedge pci_clk_i) disable iff (!rst_n_i)
      (pci_age >= 2'd2) |-> (pci_run_s == ($past(halt_dis_i, 2) | $past(pci_halt_n_i, 2))));
  end

  // R3
  cpu_park_low_chk: assert property (@(negedge cpu_clk_i) disable iff (!rst_n_i)
    !$past(cpu_run_s) |-> (cpu_clk_o == '0));
  // R3
  pci_park_low_chk: assert property (@(negedge pci_clk_i) disable iff (!rst_n_i)
    !$past(pci_run_s) |-> (pci_clk_o == '0));
  // R8
  cpu_mask_chk: assert property (@(negedge cpu_clk_i) disable iff (!rst_n_i)
    (cpu_clk_o & ~(cpu_en_i | $past(cpu_en_i))) == '0);
  // R8
  pci_mask_chk: assert property (@(negedge pci_clk_i) disable iff (!rst_n_i)
    (pci_clk_o & ~(pci_en_i | $past(pci_en_i))) == '0);
  // R6 R7
  free_run_chk: assert property (@(negedge pci_clk_i) disable iff (!rst_n_i)
    pci_free_o);
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(
  .N_CPU(N_CPU), .N_PCI(N_PCI), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .cpu_clk_i    (cpu_clk_i),
  .pci_clk_i    (pci_clk_i),
  .rst_n_i      (rst_n_i),
  .halt_dis_i   (halt_dis_i),
  .cpu_halt_n_i (cpu_halt_n_i),
  .pci_halt_n_i (pci_halt_n_i),
  .cpu_en_i     (cpu_en_i),
  .pci_en_i     (pci_en_i),
  .cpu_clk_o    (cpu_clk_o),
  .pci_clk_o    (pci_clk_o),
  .pci_free_o   (pci_free_o),
  .cpu_run_s    (cpu_run_s),
  .pci_run_s    (pci_run_s)
);

// File: tb/clkstop_ctrl_bench.sv
`timescale 1ns/1ps
module clkstop_ctrl_bench;
  localparam int N_CPU = 5;
  localparam int N_PCI = 6;

  logic             cpu_clk = 1'b0;
  logic             pci_clk = 1'b0;
  logic             rst_n;
  logic             halt_dis;
  logic             cpu_halt_n;
  logic             pci_halt_n;
  logic [N_CPU-1:0] cpu_en;
  logic [N_PCI-1:0] pci_en;
  logic [N_CPU-1:0] cpu_clk_o;
  logic [N_PCI-1:0] pci_clk_o;
  logic             pci_free_o;

  int tests = 0;
  int fails = 0;
  int runts = 0;
  int pulses = 0;
  bit done = 0;

  // 125 MHz processor clock; the PCI clock is half rate with rising edges aligned.
  always #4 cpu_clk = ~cpu_clk;
  initial begin
    #4;
    forever begin
      pci_clk = ~pci_clk;
      #8;
    end
  end

  clkstop_ctrl u_clkstop_ctrl (
    .cpu_clk_i    (cpu_clk),
    .pci_clk_i    (pci_clk),
    .rst_n_i      (rst_n),
    .halt_dis_i   (halt_dis),
    .cpu_halt_n_i (cpu_halt_n),
    .pci_halt_n_i (pci_halt_n),
    .cpu_en_i     (cpu_en),
    .pci_en_i     (pci_en),
    .cpu_clk_o    (cpu_clk_o),
    .pci_clk_o    (pci_clk_o),
    .pci_free_o   (pci_free_o)
  );

  // R3 monitor: every high pulse must have the full source width.
  logic [N_CPU-1:0] cpu_prev = '0;
  logic [N_PCI:0]   pci_prev = '0;
  time cpu_rise [N_CPU];
  time pci_rise [N_PCI+1];

  always @(cpu_clk_o) begin
    for (int i = 0; i < N_CPU; i++) begin
      if (cpu_clk_o[i] && !cpu_prev[i]) cpu_rise[i] = $time;
      else if (!cpu_clk_o[i] && cpu_prev[i]) begin
        pulses++;
        if ($time - cpu_rise[i] != 4) begin
          runts++;
          $display("FAIL R3: cpu lane %0d pulse width actual %0t expected 4", i, $time - cpu_rise[i]);
        end
      end
    end
    cpu_prev = cpu_clk_o;
  end

  always @(pci_clk_o or pci_free_o) begin
    for (int i = 0; i <= N_PCI; i++) begin
      logic v;
      v = (i == N_PCI) ? pci_free_o : pci_clk_o[i];
      if (v && !pci_prev[i]) pci_rise[i] = $time;
      else if (!v && pci_prev[i]) begin
        pulses++;
        if ($time - pci_rise[i] != 8) begin
          runts++;
          $display("FAIL R3: pci lane %0d pulse width actual %0t expected 8", i, $time - pci_rise[i]);
        end
      end
    end
    pci_prev = {pci_free_o, pci_clk_o};
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cpu_hi();
    @(posedge cpu_clk); #1;
  endtask

  task automatic pci_hi();
    @(posedge pci_clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; halt_dis = 1'b0; cpu_halt_n = 1'b0; pci_halt_n = 1'b0;
    cpu_en = '1; pci_en = '1;
    repeat (4) cpu_hi();
    check("R1 cpu runs in reset", 32'(cpu_clk_o), 32'h1f);
    pci_hi();
    check("R1 pci runs in reset", 32'(pci_clk_o), 32'h3f);
    check("R1 free runs in reset", 32'(pci_free_o), 32'h1);
    rst_n = 1'b1;
    repeat (4) pci_hi();
    check("R1 cpu halt honoured after reset", 32'(cpu_clk_o), 32'h0);
    check("R1 pci halt honoured after reset", 32'(pci_clk_o), 32'h0);
    cpu_halt_n = 1'b1; pci_halt_n = 1'b1;
    repeat (4) pci_hi();
    check("R1 running after requests drop", 32'({cpu_clk_o, pci_clk_o}), 32'h7ff);
  endtask

  task automatic t_cpu_latency();
    int last_hi = 0;
    int first_hi = 0;
    cpu_hi();
    cpu_halt_n = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      cpu_hi();
      if (|cpu_clk_o) last_hi = k;
    end
    check("R4 cpu off latency edge", 32'(last_hi), 32'd2);
    pci_hi();
    check("R6 pci runs during cpu halt", 32'(pci_clk_o), 32'h3f);
    check("R6 free runs during cpu halt", 32'(pci_free_o), 32'h1);
    cpu_hi();
    cpu_halt_n = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      cpu_hi();
      if (first_hi == 0 && |cpu_clk_o) first_hi = k;
    end
    check("R4 cpu on latency edge", 32'(first_hi), 32'd3);
  endtask

  task automatic t_pci_latency();
    int last_hi = 0;
    int first_hi = 0;
    pci_hi();
    pci_halt_n = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      pci_hi();
      if (|pci_clk_o) last_hi = k;
    end
    check("R5 pci off latency edge", 32'(last_hi), 32'd2);
    check("R7 free runs during pci halt", 32'(pci_free_o), 32'h1);
    cpu_hi();
    check("R7 cpu runs during pci halt", 32'(cpu_clk_o), 32'h1f);
    pci_hi();
    pci_halt_n = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      pci_hi();
      if (first_hi == 0 && |pci_clk_o) first_hi = k;
    end
    check("R5 pci on latency edge", 32'(first_hi), 32'd3);
  endtask

  task automatic t_mode();
    pci_hi();
    halt_dis = 1'b1; cpu_halt_n = 1'b0; pci_halt_n = 1'b0;
    repeat (6) cpu_hi();
    check("R2 cpu ignores halt when disregarded", 32'(cpu_clk_o), 32'h1f);
    pci_hi();
    check("R2 pci ignores halt when disregarded", 32'(pci_clk_o), 32'h3f);
    halt_dis = 1'b0;
    repeat (4) pci_hi();
    check("R2 cpu stops in power-management mode", 32'(cpu_clk_o), 32'h0);
    check("R2 pci stops in power-management mode", 32'(pci_clk_o), 32'h0);
    cpu_halt_n = 1'b1; pci_halt_n = 1'b1;
    repeat (4) pci_hi();
  endtask

  task automatic t_enable();
    cpu_hi();
    cpu_en = 5'b01101; pci_en = 6'b100110;
    repeat (3) pci_hi();
    check("R8 cpu masked lanes", 32'(cpu_clk_o), 32'h0d);
    check("R8 pci masked lanes", 32'(pci_clk_o), 32'h26);
    cpu_hi();
    cpu_halt_n = 1'b0;
    repeat (4) cpu_hi();
    check("R8 halt overrides enables", 32'(cpu_clk_o), 32'h0);
    cpu_halt_n = 1'b1;
    repeat (4) cpu_hi();
    check("R8 disabled lane stays low after resume", 32'(cpu_clk_o), 32'h0d);
    @(negedge cpu_clk); #1;
    check("R3 outputs low in low phase", 32'(cpu_clk_o), 32'h0);
    cpu_hi();
    cpu_en = '1; pci_en = '1;
    repeat (3) pci_hi();
    check("R8 lanes restored", 32'({cpu_clk_o, pci_clk_o}), 32'h7ff);
  endtask

  initial begin
    t_reset();
    t_cpu_latency();
    t_pci_latency();
    t_mode();
    t_enable();
    repeat (4) pci_hi();
    check("R3 pulses observed", 32'(pulses > 50), 32'h1);
    check("R3 runt pulse count", 32'(runts), 32'h0);
    fails += runts;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100us;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule